// File: doc/BRIEF.md
# Master Clock Ratio Monitor and Power Control

This block watches the relation between an audio master clock and the frame clock, and decides whether the converter path may run. In the master clock domain it counts master clock cycles from one frame clock rising edge to the next. It matches that count against the supported oversampling ratios and reports the matched ratio as a small code. It locks once two consecutive frames agree, and it asks for a mute whenever no lock is held.

In a free-running reference clock domain the block manages power. A low enable input keeps the path in its low-power state. When enable rises, the block latches the de-emphasis select pin once to choose a high-performance state. After that, the same pin acts live as the de-emphasis on/off select. A request/echo handshake between the reference clock and the master clock detects a stopped master clock and forces power-down inside a bounded window.

Top module: `clk_ratio_guard`

## Requirements
- R1: The period is the number of master clock cycles between successive frame clock rising edges. It is classified with codes 1 to 6 for ratios 128, 192, 256, 384, 512 and 768, and code 0 when no ratio matches.
- R2: A period N matches ratio R when R-8 <= N <= R+8 (both ends inclusive). A period 9 cycles away from every ratio gets code 0.
- R3: After reset or enable, the first frame clock rising edge only starts the count. `locked` goes high, and `ratio_code` shows the matched code, when two consecutive periods give the same nonzero code. `ratio_code` is 0 whenever `locked` is low.
- R4: A period that matches no ratio drops `locked` to 0 and `ratio_code` to 0 at the rising edge that ends that period.
- R5: A period that matches a different supported ratio drops the lock at that edge. The block locks to the new ratio at the next edge that ends a matching period.
- R6: `mute` is high exactly while `locked` is low. After reset: `mute`=1, `locked`=0, `ratio_code`=0, `powered_down`=1, `high_perf`=0, `deemph_en`=0.
- R7: While `enable` is low: `powered_down`=1, `locked`=0, `ratio_code`=0, `mute`=1, `high_perf`=0 and `deemph_en`=0.
- R8: On a rising edge of `enable`, `high_perf` takes the value of `deemph_sel`. Later changes of `deemph_sel` while enabled leave `high_perf` unchanged.
- R9: While enabled, `deemph_en` follows `deemph_sel` within 4 reference clock cycles.
- R10: When the master clock stops, `powered_down` rises no sooner than 1.5 us and no later than 12 us afterwards. With the default parameters this is about 3 us. When the master clock resumes, `powered_down` clears within 20 reference clock cycles.
- R11: When `enable` rises in the same reference clock cycle in which `deemph_sel` changes, `high_perf` takes the new `deemph_sel` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; clocks the ratio measurement |
| ref_clk | input | 1 | Free-running reference clock; clocks the power logic |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lrclk | input | 1 | Frame clock; its rising edges delimit measured periods |
| enable | input | 1 | High runs the path, low holds the low-power state |
| deemph_sel | input | 1 | Sampled as high-performance select at enable rise, then the live de-emphasis select |
| ratio_code | output | 3 | Locked ratio code (0 none, 1..6 = 128..768) |
| locked | output | 1 | Two consecutive periods matched the same ratio |
| mute | output | 1 | Mute / shutdown request, high while not locked |
| powered_down | output | 1 | Disabled or master clock stopped |
| high_perf | output | 1 | High-performance state latched at enable rise |
| deemph_en | output | 1 | De-emphasis filter on |

## Verification
Two functions can act in the same reference cycle: the enable-edge latch of the mode pin and the live de-emphasis select, which both read `deemph_sel` through synchronisers of equal depth. The bench changes `enable` and `deemph_sel` at the same instant, in both polarities. It expects `high_perf` to take the new pin value and `deemph_en` to follow it. The ratio sweep places periods exactly on and one cycle past both tolerance limits of every ratio. A model built from R1 to R5 gives the expected lock state for every frame.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int unsigned NUM_RATIOS = 6;
  localparam int unsigned RATIO_TBL [NUM_RATIOS] = '{128, 192, 256, 384, 512, 768};
  localparam int unsigned RATIO_MAX = RATIO_TBL[NUM_RATIOS-1];
  localparam int unsigned CODE_W = $clog2(NUM_RATIOS + 1);
endpackage

// File: rtl/ratio_classifier.sv
module ratio_classifier
  import guard_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned TOL   = 8
) (
  input  logic [CNT_W-1:0]  period,
  output logic [CODE_W-1:0] code
);
  logic [NUM_RATIOS-1:0] hit;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
    localparam int unsigned LO = RATIO_TBL[i] - TOL;
    localparam int unsigned HI = RATIO_TBL[i] + TOL;
    assign hit[i] = (32'(period) >= LO) && (32'(period) <= HI);
  end

  // Windows are at least 64 apart, so at most one bit is set.
  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_RATIOS; i++)
      if (hit[i]) code = CODE_W'(i + 1);
  end
endmodule

// File: rtl/ratio_tracker.sv
module ratio_tracker
  import guard_pkg::*;
#(
  parameter int unsigned TOL = 8
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              lrclk,
  input  logic              enable,
  output logic              lr_rise,
  output logic              locked,
  output logic [CODE_W-1:0] ratio_code
);
  localparam int unsigned CNT_W = $clog2(RATIO_MAX + TOL + 2);

  logic lr_s1, lr_s2, lr_d, en_m1, en_m2, primed;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] cls, prev_code;

  ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
    .period(cnt),
    .code  (cls)
  );

  assign lr_rise = lr_s2 & ~lr_d;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_s1 <= 1'b0; lr_s2 <= 1'b0; lr_d <= 1'b0;
      en_m1 <= 1'b0; en_m2 <= 1'b0;
    end else begin
      lr_s1 <= lrclk; lr_s2 <= lr_s1; lr_d <= lr_s2;
      en_m1 <= enable; en_m2 <= en_m1;
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; primed <= 1'b0; prev_code <= '0;
      locked <= 1'b0; ratio_code <= '0;
    end else if (!en_m2) begin
      cnt <= '0; primed <= 1'b0; prev_code <= '0;
      locked <= 1'b0; ratio_code <= '0;
    end else begin
      if (lr_rise)         cnt <= CNT_W'(1);
      else if (cnt != '1)  cnt <= cnt + 1'b1;
      if (lr_rise) begin
        primed <= 1'b1;
        if (primed) begin
          prev_code <= cls;
          if (cls != '0 && cls == prev_code) begin
            locked     <= 1'b1;
            ratio_code <= cls;
          end else begin
            locked     <= 1'b0;
            ratio_code <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mclk_stop_watch.sv
module mclk_stop_watch #(
  parameter int unsigned STOP_CYC = 150
) (
  input  logic ref_clk,
  input  logic mclk,
  input  logic rst_n,
  output logic ack_now,
  output logic stopped
);
  localparam int unsigned TW = $clog2(STOP_CYC + 1);

  logic req, echo_m1, echo_m2, ack_s1;
  logic [TW-1:0] cnt;

  // Master clock side echoes the request back.
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      echo_m1 <= 1'b0; echo_m2 <= 1'b0;
    end else begin
      echo_m1 <= req; echo_m2 <= echo_m1;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1 <= 1'b0; ack_now <= 1'b0; req <= 1'b0;
      cnt <= '0; stopped <= 1'b0;
    end else begin
      ack_s1  <= echo_m2;
      ack_now <= ack_s1;
      if (ack_now == req) begin
        req     <= ~req;
        cnt     <= '0;
        stopped <= 1'b0;
      end else begin
        if (cnt != TW'(STOP_CYC)) cnt <= cnt + 1'b1;
        if (32'(cnt) >= STOP_CYC - 1) stopped <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/power_modes.sv
module power_modes (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic enable,
  input  logic deemph_sel,
  output logic en_live,
  output logic high_perf,
  output logic deemph_en
);
  logic en_s1, en_d, dm_s1, dm_s2;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1 <= 1'b0; en_live <= 1'b0; en_d <= 1'b0;
      dm_s1 <= 1'b0; dm_s2 <= 1'b0;
      high_perf <= 1'b0; deemph_en <= 1'b0;
    end else begin
      en_s1 <= enable;     en_live <= en_s1;  en_d <= en_live;
      dm_s1 <= deemph_sel; dm_s2 <= dm_s1;
      if (!en_live)   high_perf <= 1'b0;
      else if (!en_d) high_perf <= dm_s2;
      deemph_en <= en_live & dm_s2;
    end
  end
endmodule

// File: rtl/clk_ratio_guard.sv
module clk_ratio_guard
  import guard_pkg::*;
#(
  parameter int unsigned REF_MHZ = 50,
  parameter int unsigned STOP_NS = 3000,
  parameter int unsigned TOL     = 8
) (
  input  logic        mclk,
  input  logic        ref_clk,
  input  logic        rst_n,
  input  logic        lrclk,
  input  logic        enable,
  input  logic        deemph_sel,
  output logic [2:0]  ratio_code,
  output logic        locked,
  output logic        mute,
  output logic        powered_down,
  output logic        high_perf,
  output logic        deemph_en
);
  localparam int unsigned STOP_CYC = REF_MHZ * STOP_NS / 1000;

  logic lr_rise, ack_now, stopped, en_live;
  logic [CODE_W-1:0] code_w;

  ratio_tracker #(.TOL(TOL)) u_track (
    .mclk(mclk), .rst_n(rst_n), .lrclk(lrclk), .enable(enable),
    .lr_rise(lr_rise), .locked(locked), .ratio_code(code_w)
  );

  mclk_stop_watch #(.STOP_CYC(STOP_CYC)) u_stop (
    .ref_clk(ref_clk), .mclk(mclk), .rst_n(rst_n),
    .ack_now(ack_now), .stopped(stopped)
  );

  power_modes u_pwr (
    .ref_clk(ref_clk), .rst_n(rst_n), .enable(enable), .deemph_sel(deemph_sel),
    .en_live(en_live), .high_perf(high_perf), .deemph_en(deemph_en)
  );

  assign ratio_code   = 3'(code_w);
  assign mute         = ~locked;
  assign powered_down = ~en_live | stopped;
endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
  parameter int unsigned REF_MHZ = 50
) (
  input logic       mclk,
  input logic       ref_clk,
  input logic       rst_n,
  input logic       lr_rise,
  input logic       locked,
  input logic [2:0] ratio_code,
  input logic       ack_now,
  input logic       stopped,
  input logic       en_live,
  input logic       high_perf
);
  localparam int unsigned MIN_CYC = REF_MHZ * 3 / 2;
  localparam int unsigned MAX_CYC = REF_MHZ * 12;
  localparam int unsigned SW = $clog2(MAX_CYC + 2);

  logic ack_prev;
  logic [SW-1:0] since;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_prev <= 1'b0; since <= '0;
    end else begin
      ack_prev <= ack_now;
      if (ack_now != ack_prev)      since <= '0;
      else if (since != '1)         since <= since + 1'b1;
    end
  end

  assert_code_range_R1: assert property (@(posedge mclk) disable iff (!rst_n)
    ratio_code <= 3'd6);
  assert_lock_code_R3: assert property (@(posedge mclk) disable iff (!rst_n)
    locked == (ratio_code != 3'd0));
  assert_lock_on_edge_R3: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(locked) |-> $past(lr_rise));
  assert_stop_min_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (32'(since) < MIN_CYC) |-> !stopped);
  assert_stop_max_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (32'(since) >= MAX_CYC) |-> stopped);
  assert_mode_hold_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (en_live && $past(en_live) && $past(en_live, 2)) |-> $stable(high_perf));
endmodule

bind clk_ratio_guard guard_chk #(.REF_MHZ(REF_MHZ)) u_chk (
  .mclk(mclk), .ref_clk(ref_clk), .rst_n(rst_n), .lr_rise(lr_rise),
  .locked(locked), .ratio_code(ratio_code), .ack_now(ack_now),
  .stopped(stopped), .en_live(en_live), .high_perf(high_perf)
);

// File: tb/clk_ratio_guard_tb.sv
module clk_ratio_guard_tb;
  localparam int MCLK_P = 8;
  localparam int REF_P  = 20;

  logic mclk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic lrclk = 1'b0, enable = 1'b0, deemph_sel = 1'b0;
  logic mclk_run = 1'b1;
  logic [2:0] ratio_code;
  logic locked, mute, powered_down, high_perf, deemph_en;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  bit m_primed = 0, m_locked = 0;
  int m_prev = 0, m_code = 0, m_last = 0;

  clk_ratio_guard u_dut (
    .mclk(mclk), .ref_clk(ref_clk), .rst_n(rst_n), .lrclk(lrclk),
    .enable(enable), .deemph_sel(deemph_sel), .ratio_code(ratio_code),
    .locked(locked), .mute(mute), .powered_down(powered_down),
    .high_perf(high_perf), .deemph_en(deemph_en)
  );

  always begin #(MCLK_P/2); if (mclk_run) mclk = ~mclk; end
  always #(REF_P/2) ref_clk = ~ref_clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int classify(input int n);
    int tbl [6] = '{128, 192, 256, 384, 512, 768};
    classify = 0;
    for (int i = 0; i < 6; i++)
      if (n + 8 >= tbl[i] && n <= tbl[i] + 8) classify = i + 1;
  endfunction

  task automatic wait_m(input int n); repeat (n) @(negedge mclk); endtask
  task automatic wait_r(input int n); repeat (n) @(negedge ref_clk); endtask

  task automatic model_reset();
    m_primed = 0; m_locked = 0; m_prev = 0; m_code = 0;
  endtask

  // One frame of n master clocks starting with a rising edge.
  task automatic frame(input int n);
    if (!m_primed) m_primed = 1;
    else begin
      int c = classify(m_last);
      if (c != 0 && c == m_prev) begin m_locked = 1; m_code = c; end
      else begin m_locked = 0; m_code = 0; end
      m_prev = c;
    end
    m_last = n;
    lrclk = 1'b1; wait_m(n / 2);
    lrclk = 1'b0; wait_m(n - n / 2);
  endtask

  task automatic chk_lock(input string tag);
    chk({tag, " code"},   ratio_code, m_code);
    chk({tag, " locked"}, locked,     m_locked);
    chk({tag, " mute"},   mute,       !m_locked);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int offs [5] = '{-9, -8, 0, 8, 9};
    int tbl  [6] = '{128, 192, 256, 384, 512, 768};
    wait_r(5);
    // R6 reset state
    chk("R6 reset mute", mute, 1);
    chk("R6 reset locked", locked, 0);
    chk("R6 reset code", ratio_code, 0);
    chk("R6 reset powered_down", powered_down, 1);
    chk("R6 reset high_perf", high_perf, 0);
    chk("R6 reset deemph_en", deemph_en, 0);
    rst_n = 1'b1;
    wait_r(3);
    enable = 1'b1;
    wait_r(10);
    chk("R7 enabled powered_down", powered_down, 0);
    chk("R8 latched low", high_perf, 0);
    model_reset();

    // R1 R2 R3 R4 sweep over every ratio and tolerance edge
    for (int i = 0; i < 6; i++)
      for (int k = 0; k < 5; k++) begin
        int n = tbl[i] + offs[k];
        for (int f = 0; f < 3; f++) frame(n);
        chk_lock($sformatf("R1 R2 R3 R4 ratio=%0d n=%0d", tbl[i], n));
      end

    // R5 switch between supported ratios
    for (int f = 0; f < 3; f++) frame(256);
    chk_lock("R5 locked 256");
    chk("R5 code 256", ratio_code, 3);
    frame(384); chk_lock("R5 first 384 frame");
    chk("R5 still 256", ratio_code, 3);
    frame(384); chk_lock("R5 switch drops");
    chk("R5 dropped", locked, 0);
    frame(384); chk_lock("R5 relock");
    chk("R5 code 384", ratio_code, 4);

    // R7 disable
    enable = 1'b0;
    wait_r(10); wait_m(10);
    model_reset();
    chk("R7 powered_down", powered_down, 1);
    chk("R7 locked", locked, 0);
    chk("R7 code", ratio_code, 0);
    chk("R7 mute", mute, 1);
    chk("R7 high_perf", high_perf, 0);
    chk("R7 deemph_en", deemph_en, 0);

    // R8 R9 latched mode and live select
    deemph_sel = 1'b1; wait_r(10);
    chk("R7 deemph_en stays off while disabled", deemph_en, 0);
    enable = 1'b1; wait_r(10);
    chk("R8 latched high", high_perf, 1);
    chk("R9 live on", deemph_en, 1);
    deemph_sel = 1'b0; wait_r(4);
    chk("R8 hold after pin low", high_perf, 1);
    chk("R9 live off", deemph_en, 0);
    deemph_sel = 1'b1; wait_r(4);
    chk("R9 live on again", deemph_en, 1);

    // R11 coincident enable rise and pin change
    enable = 1'b0; deemph_sel = 1'b0; wait_r(10);
    enable = 1'b1; deemph_sel = 1'b1; wait_r(10);
    chk("R11 coincident rise to 1", high_perf, 1);
    chk("R11 live follows", deemph_en, 1);
    enable = 1'b0; wait_r(10);
    enable = 1'b1; deemph_sel = 1'b0; wait_r(10);
    chk("R11 coincident fall to 0", high_perf, 0);
    chk("R11 live follows 0", deemph_en, 0);
    wait_m(10);
    model_reset();

    // R3 relock after re-enable
    for (int f = 0; f < 3; f++) frame(512);
    chk_lock("R3 relock 512");
    chk("R3 code 512", ratio_code, 5);

    // R10 stopped master clock
    @(negedge mclk); mclk_run = 1'b0;
    wait_r(75);
    chk("R10 not down before 1.5us", powered_down, 0);
    wait_r(525);
    chk("R10 down by 12us", powered_down, 1);
    mclk_run = 1'b1;
    wait_r(20);
    chk("R10 resume", powered_down, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule